// File: doc/BRIEF.md
# Level-following masked interrupt controller

This block gathers a set of level-sensitive interrupt lines into one interrupt request for a processor. Each clock, a pending register takes a copy of the input levels. Nothing is latched, so a line that drops is no longer pending one cycle later. A software-written enable mask chooses which pending lines may raise the request. The request is a register that is set whenever the masked pending image is non-zero.

Software uses a small 32-bit register bus with select, write strobe, byte address, write data and read data. The enable mask can be read and written at byte offset 0x04. The pending image is read-only at offset 0x0C. Every other offset reads as zero, and writes to them are dropped. Offsets 0x00 and 0x14 are included in this. Only word-aligned addresses decode.

Top module: `lvl_irq_agg`

## Requirements
- R1: While reset is held and on the first cycle after it, the enable mask reads 0, the pending image reads 0 and irq_out is 0.
- R2: The pending image (read at byte offset 0x0C) equals the input levels sampled at the previous rising clock edge. A line that returns low reads as 0 again after one edge.
- R3: A selected write at byte offset 0x04 loads the enable mask with bus_wdata[NUM_SRC-1:0]. A later read at 0x04 returns that value, zero-extended to 32 bits.
- R4: irq_out is 1 exactly when, one edge earlier, the enable mask AND the pending image was non-zero. With the mask unchanged, an input that rises at edge k raises irq_out after edge k+1.
- R5: A mask write at edge k leaves irq_out unchanged after edge k. The new mask shows on irq_out after edge k+1.
- R6: bus_rdata is 0 when bus_sel is 0, when bus_wr is 1, and on any read at an offset other than 0x04 and 0x0C.
- R7: Writes to offsets 0x00, 0x14, 0x08, 0x0C and every other offset except 0x04 leave the enable mask and irq_out unchanged.
- R8: An address with either of bits [1:0] set does not decode. A read returns 0, and a write does not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and interrupt clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | Level interrupt inputs, synchronous to clk |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two updates can fall on the same clock edge: a mask write and a change of the input levels. Both feed the same output register one edge later. The bench writes the mask on the same edge that an input rises or falls, in both directions. It then checks that irq_out follows the new mask and the new pending image together on the next cycle, and not either one alone. It also checks the cycle in between, where irq_out must still show the old state.

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int NUM_SRC = 32,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam logic [AW-1:0] OFS_ENABLE = AW'(8'h04);
  localparam logic [AW-1:0] OFS_PEND   = AW'(8'h0C);

  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               irq_q;
  logic [31:0]        enable_ext;
  logic [31:0]        pend_ext;

  wire hit_enable = bus_sel && (bus_addr == OFS_ENABLE);
  wire hit_pend   = bus_sel && (bus_addr == OFS_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      pend_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      pend_q <= src_lvl;
      irq_q  <= |(enable_q & pend_q);
      if (hit_enable && bus_wr)
        enable_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    enable_ext = '0;
    enable_ext[NUM_SRC-1:0] = enable_q;
    pend_ext = '0;
    pend_ext[NUM_SRC-1:0] = pend_q;
  end

  assign bus_rdata = bus_wr         ? 32'd0      :
                     hit_enable     ? enable_ext :
                     hit_pend       ? pend_ext   : 32'd0;
  assign irq_out = irq_q;
endmodule

// File: rtl/lvl_irq_agg_chk.sv
module lvl_irq_agg_chk #(
  parameter int NUM_SRC = 32,
  parameter int AW      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [NUM_SRC-1:0] pend_q
);
  assert_pend_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q == $past(src_lvl)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8'h04)) |=> (enable_q == $past(bus_wdata[NUM_SRC-1:0])));

  assert_irq_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(pend_q) != '0));

  assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(enable_q) != '0));

  assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_wr) |-> (bus_rdata == 32'd0));

  assert_other_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != AW'(8'h04)) |=> $stable(enable_q));

  assert_misaligned_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));
endmodule

bind lvl_irq_agg lvl_irq_agg_chk #(.NUM_SRC(NUM_SRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .enable_q(enable_q),
  .pend_q(pend_q)
);

// File: tb/lvl_irq_agg_bench.sv
`timescale 1ns/1ps
module lvl_irq_agg_bench;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_lvl = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lvl_irq_agg #(.NUM_SRC(N), .AW(8)) u_lvl_irq_agg (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] m;
    src_lvl = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
    rd(8'h04, v); check("R1 mask in reset", v, 32'd0);
    rd(8'h0C, v); check("R1 pend in reset", v, 32'd0);
    src_lvl = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      m = 32'hA5C3_0F01 * (i + 3) ^ (32'h1 << (i * 4));
      wr(8'h04, m);
      rd(8'h04, v); check("R3 mask readback", v, m);
    end
    wr(8'h04, 32'h0);

    for (int i = 0; i < N; i++) begin
      src_lvl = 32'h1 << i;
      @(negedge clk);
      rd(8'h0C, v); check("R2 pend walking one", v, 32'h1 << i);
    end
    src_lvl = 32'h0;
    @(negedge clk);
    rd(8'h0C, v); check("R2 pend not sticky", v, 32'h0);
    src_lvl = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(8'h0C, v); check("R2 pend pattern", v, 32'hDEAD_BEEF);

    wr(8'h04, 32'h0000_FFFF);
    for (int i = 0; i < N; i++) begin
      src_lvl = 32'h1 << i;
      @(negedge clk);
      @(negedge clk);
      check("R4 irq under half mask", {31'd0, irq_out}, {31'd0, i < 16});
    end
    for (int k = 0; k < 16; k++) begin
      m = 32'h1 << (k * 2);
      wr(8'h04, m);
      src_lvl = 32'h3 << (k * 2 + 1);
      @(negedge clk);
      @(negedge clk);
      check("R4 irq mask/pend overlap", {31'd0, irq_out}, {31'd0, ((m & src_lvl) != 0)});
    end

    wr(8'h04, 32'h0);
    src_lvl = 32'h8000_0000;
    repeat (2) @(negedge clk);
    check("R5 irq low before mask", {31'd0, irq_out}, 32'd0);
    wr(8'h04, 32'h8000_0000);
    check("R5 irq unchanged on write edge", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R5 irq high next edge", {31'd0, irq_out}, 32'd1);
    wr(8'h04, 32'h0);
    check("R5 irq still high on clear edge", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R5 irq low after clear", {31'd0, irq_out}, 32'd0);

    src_lvl = 32'h0;
    @(negedge clk);
    src_lvl = 32'h0000_0100;
    wr(8'h04, 32'h0000_0100);
    check("R4 R5 same edge, old state", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R4 R5 same edge, new state", {31'd0, irq_out}, 32'd1);
    src_lvl = 32'h0000_0200;
    wr(8'h04, 32'h0000_0200);
    @(negedge clk);
    check("R4 R5 swap same edge", {31'd0, irq_out}, 32'd1);
    src_lvl = 32'h0000_0100;
    wr(8'h04, 32'h0000_0200);
    @(negedge clk);
    check("R4 R5 diverge same edge", {31'd0, irq_out}, 32'd0);

    src_lvl = 32'hFFFF_FFFF;
    wr(8'h04, 32'h1234_5678);
    @(negedge clk);
    for (int a = 0; a < 256; a += 4) begin
      rd(a[7:0], v);
      check("R6 read decode", v, (a == 4) ? 32'h1234_5678 : (a == 12) ? 32'hFFFF_FFFF : 32'h0);
    end
    bus_addr = 8'h04; bus_sel = 1'b0; bus_wr = 1'b0;
    #1 check("R6 rdata idle", bus_rdata, 32'h0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h1234_5678;
    #1 check("R6 rdata on write", bus_rdata, 32'h0);
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);

    wr(8'h04, 32'h0);
    @(negedge clk);
    for (int a = 0; a < 256; a += 4) begin
      if (a != 4) wr(a[7:0], 32'hFFFF_FFFF);
    end
    rd(8'h04, v); check("R7 mask after other writes", v, 32'h0);
    @(negedge clk);
    check("R7 irq after other writes", {31'd0, irq_out}, 32'd0);

    wr(8'h04, 32'h0000_00F0);
    for (int a = 5; a < 8; a++) begin
      wr(a[7:0], 32'hFFFF_FFFF);
      rd(8'h04, v); check("R8 misaligned write", v, 32'h0000_00F0);
      rd(a[7:0], v); check("R8 misaligned read", v, 32'h0);
    end
    rd(8'h0D, v); check("R8 misaligned pend read", v, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule